// File: doc/BRIEF.md
# Single-Cycle Processor Core

This core executes one 32-bit instruction in every clock cycle. The supported subset is five register-to-register operations (add, sub, and, or, set-on-less-than), word load, word store, branch-if-equal and an absolute jump. The PC, the 32-entry register file and external data memory change only at the clock edge. Everything between instruction fetch and write-back is combinational.

Control is decoded in two levels. A main decoder looks only at the opcode. It produces the datapath strobes and a 2-bit ALU class. A second decoder combines that class with the function field to give the 3-bit ALU operation. A branch is taken when the branch strobe is set and the ALU reports a zero result.

Instructions are held in an internal instruction memory. It is filled through a load port, normally while the core is held in reset. Data memory sits outside the core and is reached through a word-addressed port. Read data comes back combinationally in the same cycle.

Top module: `scp_core`

## Requirements
- R1: While `rstN` is low, the PC is 0. Execution starts at byte address 0 after release.
- R2: An instruction that is neither a taken branch nor a jump advances the PC by 4. An unknown opcode changes no state.
- R3: Opcode 000000 with funct 100000, 100010, 100100 or 100101 writes rs+rt, rs−rt, rs AND rt or rs OR rt into register rd (bits 15:11). rs is bits 25:21 and rt is bits 20:16.
- R4: Opcode 000000 with funct 101010 writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R5: Opcode 100011 (load) asserts `dmemRe` only for that instruction. It writes `dmemRdata` into register rt (bits 20:16).
- R6: Opcode 101011 (store) asserts `dmemWe` and drives register rt on `dmemWdata`. No other instruction asserts `dmemWe`.
- R7: Opcode 000100 with equal rs and rt loads the PC with PC+4 + (sign-extended imm16 << 2). Backward offsets are included.
- R8: Opcode 000100 with unequal rs and rt advances the PC by 4.
- R9: Opcode 000010 loads the PC with {PC+4[31:28], instr[25:0], 2'b00}.
- R10: Register 0 always reads as zero. A write to it is discarded.
- R11: The 16-bit immediate of loads and stores is sign-extended before it is added to rs.
- R12: Loads and stores use the add operation and beq uses subtract. For loads and stores, `dmemAddr` is bits [DMEM_AW+1:2] of rs + immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the PC |
| loadEn | input | 1 | Write strobe for the instruction memory |
| loadAddr | input | IMEM_AW | Word index written by the load port |
| loadData | input | 32 | Instruction word to store |
| pc | output | 32 | Current instruction byte address |
| dmemAddr | output | DMEM_AW | Data memory word address |
| dmemWdata | output | 32 | Store data |
| dmemWe | output | 1 | Data memory write strobe |
| dmemRe | output | 1 | Data memory read strobe |
| dmemRdata | input | 32 | Combinational load data |

## Verification
One program exercises every arithmetic function on a positive operand and a negative operand. This separates signed set-less-than from the unsigned form, and a swapped subtract shows up as a sign change. A write to register 0 followed by a store of register 0 shows whether the write was dropped. The branch checks cover four cases: a not-taken compare, a forward taken compare, a jump over two stores, and a backward self-loop. A store at a negative offset from a base register shows whether the immediate is sign-extended. Each cycle the PC and both memory strobes are compared with a reference instruction model. Every store also has its address and data compared.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluCtl_e;

  typedef enum logic [1:0] {
    AOP_MEM   = 2'b00,
    AOP_BR    = 2'b01,
    AOP_FUNCT = 2'b10
  } aluClass_e;

  typedef struct packed {
    logic regDst;
    logic aluSrc;
    logic memToReg;
    logic regWrite;
    logic memRead;
    logic memWrite;
    logic branch;
    logic jump;
  } mainCtl_t;

  typedef struct packed {
    mainCtl_t m;
    aluCtl_e  aluCtl;
  } ctrl_t;

endpackage

// File: rtl/scp_main_dec.sv
module scp_main_dec
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  output mainCtl_t   mainCtl,
  output aluClass_e  aluClass
);

  always_comb begin
    mainCtl  = '0;
    aluClass = AOP_MEM;
    unique case (opcode)
      OP_RTYPE: begin
        mainCtl.regDst   = 1'b1;
        mainCtl.regWrite = 1'b1;
        aluClass         = AOP_FUNCT;
      end
      OP_LW: begin
        mainCtl.aluSrc   = 1'b1;
        mainCtl.memToReg = 1'b1;
        mainCtl.regWrite = 1'b1;
        mainCtl.memRead  = 1'b1;
      end
      OP_SW: begin
        mainCtl.aluSrc   = 1'b1;
        mainCtl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        mainCtl.branch = 1'b1;
        aluClass       = AOP_BR;
      end
      OP_J: begin
        mainCtl.jump = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scp_alu_dec.sv
module scp_alu_dec
  import scp_pkg::*;
(
  input  aluClass_e  aluClass,
  input  logic [5:0] funct,
  output aluCtl_e    aluCtl
);

  always_comb begin
    aluCtl = ALU_ADD;
    unique case (aluClass)
      AOP_MEM: aluCtl = ALU_ADD;
      AOP_BR:  aluCtl = ALU_SUB;
      default: begin
        case (funct)
          FN_ADD:  aluCtl = ALU_ADD;
          FN_SUB:  aluCtl = ALU_SUB;
          FN_AND:  aluCtl = ALU_AND;
          FN_OR:   aluCtl = ALU_OR;
          FN_SLT:  aluCtl = ALU_SLT;
          default: aluCtl = ALU_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int AW = 5,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] raddr1,
  input  logic [AW-1:0] raddr2,
  output logic [W-1:0]  rdata1,
  output logic [W-1:0]  rdata2,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);

  localparam int NREGS = 1 << AW;

  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (wen && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
  assign rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];

endmodule

// File: rtl/scp_datapath.sv
module scp_datapath
  import scp_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  output logic [5:0]         opcode,
  output logic [5:0]         funct,
  input  logic               loadEn,
  input  logic [IMEM_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  output logic [31:0]        pc,
  output logic [DMEM_AW-1:0] dmemAddr,
  output logic [31:0]        dmemWdata,
  output logic               dmemWe,
  output logic               dmemRe,
  input  logic [31:0]        dmemRdata
);

  localparam int IMEM_DEPTH = 1 << IMEM_AW;
  localparam int REG_AW     = 5;

  logic [31:0] imem [IMEM_DEPTH];
  logic [31:0] pcReg, pcPlus4, pcNext, brTarget, jTarget;
  logic [31:0] instr, immExt;
  logic [31:0] rd1, rd2, aluB, aluY, wbData;
  logic [REG_AW-1:0] wAddr;
  logic aluZero, takeBranch;

  // instruction store, filled through the load port
  always_ff @(posedge clk) begin
    if (loadEn) imem[loadAddr] <= loadData;
  end

  assign instr  = imem[pcReg[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign immExt = {{16{instr[15]}}, instr[15:0]};

  // register file and write-back
  assign wAddr  = ctrl.m.regDst ? instr[15:11] : instr[20:16];
  assign wbData = ctrl.m.memToReg ? dmemRdata : aluY;

  scp_regfile #(.AW(REG_AW), .W(32)) u_rf (
    .clk   (clk),
    .raddr1(instr[25:21]),
    .raddr2(instr[20:16]),
    .rdata1(rd1),
    .rdata2(rd2),
    .wen   (ctrl.m.regWrite),
    .waddr (wAddr),
    .wdata (wbData)
  );

  // ALU
  assign aluB = ctrl.m.aluSrc ? immExt : rd2;

  always_comb begin
    unique case (ctrl.aluCtl)
      ALU_AND: aluY = rd1 & aluB;
      ALU_OR:  aluY = rd1 | aluB;
      ALU_ADD: aluY = rd1 + aluB;
      ALU_SUB: aluY = rd1 - aluB;
      ALU_SLT: aluY = {31'b0, $signed(rd1) < $signed(aluB)};
      default: aluY = rd1 + aluB;
    endcase
  end

  assign aluZero = (aluY == 32'd0);

  // next PC
  assign pcPlus4    = pcReg + 32'd4;
  assign brTarget   = pcPlus4 + {immExt[29:0], 2'b00};
  assign jTarget    = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign takeBranch = ctrl.m.branch & aluZero;

  always_comb begin
    if (ctrl.m.jump)     pcNext = jTarget;
    else if (takeBranch) pcNext = brTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcReg <= '0;
    else       pcReg <= pcNext;
  end

  assign pc        = pcReg;
  assign dmemAddr  = aluY[DMEM_AW+1:2];
  assign dmemWdata = rd2;
  assign dmemWe    = ctrl.m.memWrite;
  assign dmemRe    = ctrl.m.memRead;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(takeBranch) && !$past(ctrl.m.jump)) |-> pcReg == $past(pcReg) + 32'd4)
    else $error("sequential PC step broken"); // R2

  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(takeBranch) && !$past(ctrl.m.jump)) |->
      pcReg == $past(pcReg) + 32'd4 + {$past(immExt[29:0]), 2'b00})
    else $error("branch target wrong"); // R7

  AST_J_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(ctrl.m.jump)) |-> pcReg[27:0] == {$past(instr[25:0]), 2'b00})
    else $error("jump target wrong"); // R9

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [IMEM_AW-1:0] loadAddr,
  input  logic [31:0]        loadData,
  output logic [31:0]        pc,
  output logic [DMEM_AW-1:0] dmemAddr,
  output logic [31:0]        dmemWdata,
  output logic               dmemWe,
  output logic               dmemRe,
  input  logic [31:0]        dmemRdata
);

  logic [5:0] opcode, funct;
  mainCtl_t   mainCtl;
  aluClass_e  aluClass;
  aluCtl_e    aluCtl;
  ctrl_t      ctrl;

  scp_main_dec u_main (
    .opcode  (opcode),
    .mainCtl (mainCtl),
    .aluClass(aluClass)
  );

  scp_alu_dec u_aluDec (
    .aluClass(aluClass),
    .funct   (funct),
    .aluCtl  (aluCtl)
  );

  assign ctrl.m      = mainCtl;
  assign ctrl.aluCtl = aluCtl;

  scp_datapath #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .funct    (funct),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .pc       (pc),
    .dmemAddr (dmemAddr),
    .dmemWdata(dmemWdata),
    .dmemWe   (dmemWe),
    .dmemRe   (dmemRe),
    .dmemRdata(dmemRdata)
  );

  AST_MEM_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (mainCtl.memRead || mainCtl.memWrite) |-> aluCtl == ALU_ADD)
    else $error("memory access not using add"); // R12

  AST_BR_SUB: assert property (@(posedge clk) disable iff (!rstN)
    mainCtl.branch |-> aluCtl == ALU_SUB)
    else $error("branch compare not using subtract"); // R12

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    dmemWe |-> !mainCtl.regWrite)
    else $error("store also writes a register"); // R6

endmodule

// File: tb/sim_scp_core.sv
`timescale 1ns/1ps
module sim_scp_core;
  localparam int IAW = 6;
  localparam int DAW = 8;
  localparam int NI  = 1 << IAW;
  localparam int ND  = 1 << DAW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rstN = 1'b0;
  logic           loadEn = 1'b0;
  logic [IAW-1:0] loadAddr = '0;
  logic [31:0]    loadData = '0;
  logic [31:0]    pc, dmemWdata, dmemRdata;
  logic [DAW-1:0] dmemAddr;
  logic           dmemWe, dmemRe;

  scp_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .pc(pc), .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemWe(dmemWe),
    .dmemRe(dmemRe), .dmemRdata(dmemRdata)
  );

  // external data memory model
  logic [31:0] bmem [ND];
  assign dmemRdata = bmem[dmemAddr];
  always @(posedge clk) if (dmemWe) bmem[dmemAddr] <= dmemWdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0]    pc;
    logic           we;
    logic           re;
    logic [DAW-1:0] addr;
    logic [31:0]    data;
    string          pcTag;
    string          stTag;
    string          adTag;
  } item_t;

  item_t       q[$];
  logic [31:0] prog [NI];
  string       stTagOf [NI];
  logic [31:0] memInit [ND];

  function automatic logic [31:0] enR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b0, fn};
  endfunction
  function automatic logic [31:0] enI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: runs a reference instruction model and queues the expected items
  task automatic drive_expect(int n);
    logic [31:0] r [32];
    logic [31:0] m [ND];
    logic [31:0] mpc = 32'd0;
    string tag = "R1";
    for (int i = 0; i < 32; i++) r[i] = 32'd0;
    for (int i = 0; i < ND; i++) m[i] = memInit[i];
    for (int k = 0; k < n; k++) begin
      logic [31:0] ins, sx, ea, npc;
      logic [5:0]  op;
      logic [4:0]  rs, rt, rd;
      item_t it;
      ins = prog[mpc[IAW+1:2]];
      op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      sx = {{16{ins[15]}}, ins[15:0]};
      ea = r[rs] + sx;
      it.pc = mpc; it.we = (op == 6'b101011); it.re = (op == 6'b100011);
      it.addr = ea[DAW+1:2]; it.data = r[rt]; it.pcTag = tag;
      it.stTag = stTagOf[mpc[IAW+1:2]];
      it.adTag = ins[15] ? "R11" : "R12";
      q.push_back(it);
      npc = mpc + 32'd4;
      tag = "R2";
      case (op)
        6'b000000: begin
          logic [31:0] v;
          case (ins[5:0])
            6'b100000: v = r[rs] + r[rt];
            6'b100010: v = r[rs] - r[rt];
            6'b100100: v = r[rs] & r[rt];
            6'b100101: v = r[rs] | r[rt];
            6'b101010: v = ($signed(r[rs]) < $signed(r[rt])) ? 32'd1 : 32'd0;
            default:   v = r[rs] + r[rt];
          endcase
          if (rd != 0) r[rd] = v;
        end
        6'b100011: if (rt != 0) r[rt] = m[ea[DAW+1:2]];
        6'b101011: m[ea[DAW+1:2]] = r[rt];
        6'b000100: begin
          if (r[rs] == r[rt]) begin
            npc = npc + {sx[29:0], 2'b00};
            tag = "R7";
          end else tag = "R8";
        end
        6'b000010: begin
          npc = {npc[31:28], ins[25:0], 2'b00};
          tag = "R9";
        end
        default: ;
      endcase
      mpc = npc;
    end
  endtask

  initial begin
    for (int i = 0; i < ND; i++) memInit[i] = 32'h100 + i;
    memInit[0] = 32'd7;
    memInit[1] = 32'hFFFF_FFF6;
    memInit[2] = 32'd64;
    for (int i = 0; i < ND; i++) bmem[i] = memInit[i];
    for (int i = 0; i < NI; i++) begin prog[i] = 32'd0; stTagOf[i] = "R6"; end

    prog[0]  = enI(6'b100011, 0, 1, 16'd0);       // lw r1
    prog[1]  = enI(6'b100011, 0, 2, 16'd4);       // lw r2
    prog[2]  = enR(1, 2, 3, 6'b100000);           // add
    prog[3]  = enR(1, 2, 4, 6'b100010);           // sub
    prog[4]  = enR(1, 2, 5, 6'b100100);           // and
    prog[5]  = enR(1, 2, 6, 6'b100101);           // or
    prog[6]  = enR(1, 2, 7, 6'b101010);           // slt 7 < -10
    prog[7]  = enR(2, 1, 8, 6'b101010);           // slt -10 < 7
    for (int i = 0; i < 6; i++) prog[8+i] = enI(6'b101011, 0, 5'(3+i), 16'(16 + 4*i));
    prog[14] = enR(1, 2, 0, 6'b100000);           // write to r0
    prog[15] = enI(6'b101011, 0, 0, 16'd40);      // store r0
    prog[16] = enI(6'b000100, 1, 2, 16'd5);       // beq not taken
    prog[17] = enI(6'b000100, 1, 1, 16'd2);       // beq taken -> 20
    prog[18] = enI(6'b101011, 0, 1, 16'd44);
    prog[19] = enI(6'b101011, 0, 1, 16'd48);
    prog[20] = {6'b000010, 26'd23};               // j -> 23
    prog[21] = enI(6'b101011, 0, 1, 16'd52);
    prog[22] = enI(6'b101011, 0, 1, 16'd60);
    prog[23] = enI(6'b100011, 0, 10, 16'd8);      // lw r10 = 64
    prog[24] = enI(6'b101011, 10, 3, 16'hFFF8);   // sw r3, -8(r10)
    prog[25] = enI(6'b000100, 0, 0, 16'hFFFF);    // backward self-loop
    stTagOf[8] = "R3"; stTagOf[9] = "R3"; stTagOf[10] = "R3"; stTagOf[11] = "R3";
    stTagOf[12] = "R4"; stTagOf[13] = "R4"; stTagOf[15] = "R10"; stTagOf[24] = "R5";

    for (int i = 0; i < NI; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = IAW'(i); loadData = prog[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    check(pc == 32'd0, "R1", "pc in reset", pc, 32'd0);
    @(negedge clk);
    check(pc == 32'd0, "R1", "pc held in reset", pc, 32'd0);

    drive_expect(40);
    rstN = 1'b1;

    // monitor: pop and compare one expected item per cycle
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(pc == it.pc, it.pcTag, "pc", pc, it.pc);
      check(dmemWe == it.we, "R6", "store strobe", 32'(dmemWe), 32'(it.we));
      check(dmemRe == it.re, "R5", "load strobe", 32'(dmemRe), 32'(it.re));
      if (it.we && dmemWe) begin
        check(dmemAddr == it.addr, it.adTag, "store address", 32'(dmemAddr), 32'(it.addr));
        check(dmemWdata == it.data, it.stTag, "store data", dmemWdata, it.data);
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule